// File: doc/BRIEF.md
# Two-Plane Block Erase Sequencer

This block sits on the host side of a two-plane NAND flash device. It erases one block in each plane at the same time. A start request carries two row addresses. The block first checks that the two rows lie in different planes. It then drives the command and address cycles on the 8-bit flash bus, issues one erase-confirm command for both blocks, and waits until the device is ready again. Completion is found either by watching the ready/busy pin or by polling the status byte. Either way, the block ends by reading the status byte, and bit 0 of that byte becomes the pass/fail result.

Each row address is sent as `ADDR_CYC` address cycles, least significant byte first. The two setup groups are sent back to back, with no wait between them. Bit `PLANE_BIT` of a row address selects the plane. A counter limits how long the block waits for ready. If the limit is reached, the operation is abandoned and reported as a timeout.

Top module: `dual_plane_erase`

## Requirements
- R1: An accepted erase issues exactly nine write cycles, in this order: command 0x60, the three bytes of `row_a_i` (bits 7:0, then 15:8, then 23:16), command 0x60, the three bytes of `row_b_i` in the same order, and command 0xD0. Command cycles have CLE=1 and ALE=0. Address cycles have ALE=1 and CLE=0.
- R2: Each bus cycle holds its strobe (WE# or RE#) low for one clock and high for one clock. A new cycle starts every 3 clocks, so all nine erase cycles are evenly spaced and no busy wait sits between the two address groups.
- R3: Bit 6 (`PLANE_BIT`) selects the plane of each row address. If both rows select the same plane, the request is rejected: `addr_err_o` is set, `done_o` pulses, and no bus cycle occurs (CE# stays high).
- R4: With `mode_poll_i`=0, the block waits `BUSY_GUARD` clocks after the confirm cycle and then waits for R/B# high. Only then does it issue command 0x70 and read the status byte once.
- R5: With `mode_poll_i`=1, the block issues command 0x70 right after the confirm cycle. It then reads the status repeatedly until bit 6 (ready) is 1, without looking at R/B#.
- R6: `fail_o` equals bit 0 of the status byte that showed ready.
- R7: Counting starts when the confirm cycle ends. If ready has not been seen within `timeout_i` clocks, the operation ends with `tmo_err_o`=1, `fail_o`=0 and a `done_o` pulse.
- R8: `done_o` is a one-clock pulse. `busy_o` is high from an accepted start until the done pulse. A start while busy is ignored. The result flags hold until the next accepted start.
- R9: After reset, CE#, WE# and RE# are high, CLE, ALE and `nand_io_oe_o` are low, and `busy_o`, `done_o` and all flags are low.
- R10: `nand_io_oe_o` is high during command and address cycles and low during status reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request pulse |
| row_a_i | input | 24 | Row address of the first block |
| row_b_i | input | 24 | Row address of the second block |
| mode_poll_i | input | 1 | 1: poll the status byte, 0: watch R/B# |
| timeout_i | input | 16 | Ready wait limit in clocks |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_n_o | output | 1 | Write strobe, active low |
| nand_re_n_o | output | 1 | Read strobe, active low |
| nand_ce_n_o | output | 1 | Chip enable, active low |
| nand_io_o | output | 8 | Bus data out |
| nand_io_oe_o | output | 1 | Bus output enable |
| nand_io_i | input | 8 | Bus data in |
| nand_rb_n_i | input | 1 | Ready/busy from the device, low while busy |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-clock completion pulse |
| fail_o | output | 1 | Device reported erase failure |
| addr_err_o | output | 1 | Rows selected the same plane |
| tmo_err_o | output | 1 | Ready not seen in time |

## Verification
The bench targets the joins between phases:
- **Address-group spacing.** It times the gap between the last byte of the first address group and the second setup command. A design that inserted a wait there, or held a strobe for two clocks, would show a gap other than 3 clocks or duplicated cycles.
- **R/B# mode with an instant device.** It runs R/B# mode against a device that never drops R/B#. A design without the guard interval would then read status too early.
- **Timeouts in both modes.** A design whose counter ignores one mode would hang there.
- **Same-plane pairs.** A design that only flagged the error would still put cycles on the bus.
- **Start while busy.** A design that accepted a second start would issue a second command stream.

// File: rtl/nand_erase_pkg.sv
package nand_erase_pkg;

  typedef enum logic [1:0] {BUS_CMD, BUS_ADDR, BUS_READ} bus_kind_e;

  typedef struct packed {
    bus_kind_e  kind;
    logic [7:0] data;
  } bus_item_t;

  localparam logic [7:0] OP_ERASE_SETUP = 8'h60;
  localparam logic [7:0] OP_ERASE_GO    = 8'hD0;
  localparam logic [7:0] OP_STATUS      = 8'h70;

  localparam int ST_READY_BIT = 6;
  localparam int ST_FAIL_BIT  = 0;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_ISSUE, SQ_WAIT_RB, SQ_ST_CMD, SQ_ST_READ, SQ_FIN
  } seq_state_e;

endpackage

// File: rtl/erase_plane_check.sv
module erase_plane_check #(
  parameter int ROW_W     = 24,
  parameter int PLANE_BIT = 6
) (
  input  logic [ROW_W-1:0] row_a_i,
  input  logic [ROW_W-1:0] row_b_i,
  output logic             planes_ok_o
);

  function automatic logic plane_of(input logic [ROW_W-1:0] row);
    return row[PLANE_BIT];
  endfunction

  assign planes_ok_o = plane_of(row_a_i) != plane_of(row_b_i);

endmodule

// File: rtl/nand_bus_cycle.sv
module nand_bus_cycle
  import nand_erase_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_i,
  input  bus_item_t  item_i,
  output logic       idle_o,
  output logic       done_o,
  output logic       cle_o,
  output logic       ale_o,
  output logic       we_n_o,
  output logic       re_n_o,
  output logic [7:0] io_o,
  output logic       io_oe_o,
  input  logic [7:0] io_i,
  output logic [7:0] rd_data_o
);

  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} phase_e;

  phase_e     ph;
  bus_kind_e  kind_q;
  logic [7:0] data_q;
  logic [7:0] rd_q;
  logic       active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      kind_q <= BUS_CMD;
      data_q <= '0;
      rd_q   <= '0;
    end else begin
      case (ph)
        PH_IDLE: if (req_i) begin
          ph     <= PH_LOW;
          kind_q <= item_i.kind;
          data_q <= item_i.data;
        end
        PH_LOW: begin
          ph <= PH_HIGH;
          if (kind_q == BUS_READ) rd_q <= io_i;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign active    = ph != PH_IDLE;
  assign idle_o    = ph == PH_IDLE;
  assign done_o    = ph == PH_HIGH;
  assign cle_o     = active && kind_q == BUS_CMD;
  assign ale_o     = active && kind_q == BUS_ADDR;
  assign we_n_o    = !(ph == PH_LOW && kind_q != BUS_READ);
  assign re_n_o    = !(ph == PH_LOW && kind_q == BUS_READ);
  assign io_oe_o   = active && kind_q != BUS_READ;
  assign io_o      = io_oe_o ? data_q : 8'h00;
  assign rd_data_o = rd_q;

  // R1: latch enables never both high
  a_r1_cle_ale_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle_o && ale_o));
  // R10: no output drive while read strobe is low
  a_r10_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n_o |-> !io_oe_o);
  // R2: write strobe low for exactly one clock
  a_r2_strobe_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n_o |=> we_n_o);

endmodule

// File: rtl/erase_wait_timer.sv
module erase_wait_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clear_i)          cnt <= '0;
    else if (run_i && !(&cnt)) cnt <= cnt + 1'b1;
  end

  assign count_o   = cnt;
  assign expired_o = cnt >= limit_i;

  // R7: counter restarts from zero
  a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> count_o == '0);
  // R7: counter advances one per waiting clock
  a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !clear_i && !(&count_o)) |=> count_o == $past(count_o) + 1'b1);

endmodule

// File: rtl/dual_plane_erase.sv
module dual_plane_erase
  import nand_erase_pkg::*;
#(
  parameter int ADDR_CYC   = 3,
  parameter int PLANE_BIT  = 6,
  parameter int TMO_W      = 16,
  parameter int BUSY_GUARD = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [8*ADDR_CYC-1:0] row_a_i,
  input  logic [8*ADDR_CYC-1:0] row_b_i,
  input  logic                  mode_poll_i,
  input  logic [TMO_W-1:0]      timeout_i,
  output logic                  nand_cle_o,
  output logic                  nand_ale_o,
  output logic                  nand_we_n_o,
  output logic                  nand_re_n_o,
  output logic                  nand_ce_n_o,
  output logic [7:0]            nand_io_o,
  output logic                  nand_io_oe_o,
  input  logic [7:0]            nand_io_i,
  input  logic                  nand_rb_n_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  fail_o,
  output logic                  addr_err_o,
  output logic                  tmo_err_o
);

  localparam int ROW_W   = 8 * ADDR_CYC;
  localparam int GRP_LEN = 1 + ADDR_CYC;
  localparam int N_STEPS = 2 * GRP_LEN + 1;
  localparam int STEP_W  = $clog2(N_STEPS + 1);
  localparam logic [TMO_W-1:0] GUARD = TMO_W'(BUSY_GUARD);

  function automatic bus_item_t erase_step(input logic [STEP_W-1:0] idx,
                                           input logic [ROW_W-1:0] ra,
                                           input logic [ROW_W-1:0] rb);
    int unsigned i;
    int unsigned pos;
    logic [ROW_W-1:0] row;
    i = 32'(idx);
    if (i >= N_STEPS - 1) return '{BUS_CMD, OP_ERASE_GO};
    pos = i % GRP_LEN;
    row = (i < GRP_LEN) ? ra : rb;
    if (pos == 0) return '{BUS_CMD, OP_ERASE_SETUP};
    return '{BUS_ADDR, 8'(row >> (8 * (pos - 1)))};
  endfunction

  seq_state_e        st;
  logic [STEP_W-1:0] step;
  logic [ROW_W-1:0]  row_a_q, row_b_q;
  logic              poll_q;
  logic [TMO_W-1:0]  lim_q;
  logic              fail_q, aerr_q, terr_q;

  logic              planes_ok;
  logic              cg_idle, cg_done, cg_req;
  bus_item_t         cg_item;
  logic [7:0]        rd_data;
  logic              tm_clear, tm_run, tm_expired;
  logic [TMO_W-1:0]  tm_count;
  logic              wait_state, abort_now, issue_more;

  erase_plane_check #(.ROW_W(ROW_W), .PLANE_BIT(PLANE_BIT)) u_check (
    .row_a_i     (row_a_i),
    .row_b_i     (row_b_i),
    .planes_ok_o (planes_ok)
  );

  assign wait_state = st == SQ_WAIT_RB || st == SQ_ST_CMD || st == SQ_ST_READ;
  assign tm_clear   = st == SQ_IDLE || st == SQ_ISSUE;
  assign tm_run     = wait_state;
  assign abort_now  = wait_state && tm_expired && (st == SQ_WAIT_RB || cg_idle);
  assign issue_more = st == SQ_ISSUE && step < STEP_W'(N_STEPS);

  erase_wait_timer #(.CNT_W(TMO_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (tm_clear),
    .run_i     (tm_run),
    .limit_i   (lim_q),
    .count_o   (tm_count),
    .expired_o (tm_expired)
  );

  always_comb begin
    cg_item = '{BUS_READ, 8'h00};
    if (st == SQ_ISSUE)       cg_item = erase_step(step, row_a_q, row_b_q);
    else if (st == SQ_ST_CMD) cg_item = '{BUS_CMD, OP_STATUS};
  end

  assign cg_req = cg_idle && !abort_now &&
                  (issue_more || st == SQ_ST_CMD || st == SQ_ST_READ);

  nand_bus_cycle u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (cg_req),
    .item_i    (cg_item),
    .idle_o    (cg_idle),
    .done_o    (cg_done),
    .cle_o     (nand_cle_o),
    .ale_o     (nand_ale_o),
    .we_n_o    (nand_we_n_o),
    .re_n_o    (nand_re_n_o),
    .io_o      (nand_io_o),
    .io_oe_o   (nand_io_oe_o),
    .io_i      (nand_io_i),
    .rd_data_o (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= SQ_IDLE;
      step    <= '0;
      row_a_q <= '0;
      row_b_q <= '0;
      poll_q  <= 1'b0;
      lim_q   <= '0;
      fail_q  <= 1'b0;
      aerr_q  <= 1'b0;
      terr_q  <= 1'b0;
    end else begin
      case (st)
        SQ_IDLE: if (start_i) begin
          row_a_q <= row_a_i;
          row_b_q <= row_b_i;
          poll_q  <= mode_poll_i;
          lim_q   <= timeout_i;
          fail_q  <= 1'b0;
          terr_q  <= 1'b0;
          step    <= '0;
          aerr_q  <= !planes_ok;
          st      <= planes_ok ? SQ_ISSUE : SQ_FIN;
        end
        SQ_ISSUE: begin
          if (cg_done) step <= step + 1'b1;
          if (cg_idle && step == STEP_W'(N_STEPS))
            st <= poll_q ? SQ_ST_CMD : SQ_WAIT_RB;
        end
        SQ_WAIT_RB: begin
          if (abort_now) begin
            terr_q <= 1'b1;
            st     <= SQ_FIN;
          end else if (tm_count >= GUARD && nand_rb_n_i) begin
            st <= SQ_ST_CMD;
          end
        end
        SQ_ST_CMD: begin
          if (abort_now) begin
            terr_q <= 1'b1;
            st     <= SQ_FIN;
          end else if (cg_done) begin
            st <= SQ_ST_READ;
          end
        end
        SQ_ST_READ: begin
          if (abort_now) begin
            terr_q <= 1'b1;
            st     <= SQ_FIN;
          end else if (cg_done && rd_data[ST_READY_BIT]) begin
            fail_q <= rd_data[ST_FAIL_BIT];
            st     <= SQ_FIN;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign nand_ce_n_o = !(st == SQ_ISSUE || wait_state);
  assign busy_o      = st != SQ_IDLE;
  assign done_o      = st == SQ_FIN;
  assign fail_o      = fail_q;
  assign addr_err_o  = aerr_q;
  assign tmo_err_o   = terr_q;

  // R3: same-plane request goes straight to completion with the bus idle
  a_r3_reject_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_IDLE && start_i && !planes_ok) |=> (st == SQ_FIN && nand_ce_n_o && cg_idle));
  // R8: completion pulse lasts one clock
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R4: no strobe while waiting on R/B#
  a_r4_quiet_wait: assert property (@(posedge clk) disable iff (!rst_n)
    st == SQ_WAIT_RB |-> (nand_we_n_o && nand_re_n_o));
  // R7: timeout flag only after the wait counter expired
  a_r7_tmo_after_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_err_o) |-> $past(tm_expired));

endmodule

// File: tb/dual_plane_erase_test.sv
module dual_plane_erase_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam int GUARD      = 4;

  typedef struct packed {
    logic [23:0] ra;
    logic [23:0] rb;
    logic        poll;
    logic [15:0] blen;
    logic        sfail;
    logic [15:0] tmo;
    logic        e_aerr;
    logic        e_fail;
    logic        e_tmo;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{24'h012340, 24'h045600, 1'b0, 16'd20,  1'b0, 16'd1000, 1'b0, 1'b0, 1'b0},
    '{24'h0A0B0C, 24'h1F2E4D, 1'b1, 16'd30,  1'b1, 16'd1000, 1'b0, 1'b1, 1'b0},
    '{24'h000040, 24'h7FFFC0, 1'b0, 16'd10,  1'b0, 16'd1000, 1'b1, 1'b0, 1'b0},
    '{24'h000000, 24'h000040, 1'b0, 16'd300, 1'b0, 16'd100,  1'b0, 1'b0, 1'b1},
    '{24'h112233, 24'h4455C6, 1'b1, 16'd300, 1'b1, 16'd60,   1'b0, 1'b0, 1'b1},
    '{24'hABCD7F, 24'h00EE80, 1'b0, 16'd0,   1'b1, 16'd1000, 1'b0, 1'b1, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] row_a = '0, row_b = '0;
  logic        poll = 1'b0;
  logic [15:0] tmo = '0;
  logic        cle, ale, we_n, re_n, ce_n, io_oe;
  logic [7:0]  io_out, io_in;
  logic        rb_n;
  logic        busy, done, fail, aerr, terr;

  int errors = 0;
  int checks = 0;
  int tick = 0;
  int busy_cnt = 0;
  int blen = 0;
  logic sfail = 1'b0;
  int log_n = 0;
  int rd_n = 0;
  int oe_bad = 0;
  logic [7:0] log_d [64];
  logic       log_c [64];
  logic       log_a [64];
  int         log_t [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_plane_erase uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .row_a_i(row_a), .row_b_i(row_b),
    .mode_poll_i(poll), .timeout_i(tmo),
    .nand_cle_o(cle), .nand_ale_o(ale), .nand_we_n_o(we_n), .nand_re_n_o(re_n),
    .nand_ce_n_o(ce_n), .nand_io_o(io_out), .nand_io_oe_o(io_oe), .nand_io_i(io_in),
    .nand_rb_n_i(rb_n), .busy_o(busy), .done_o(done), .fail_o(fail),
    .addr_err_o(aerr), .tmo_err_o(terr)
  );

  assign rb_n  = busy_cnt == 0;
  assign io_in = {1'b0, busy_cnt == 0, 5'b0, sfail};

  // device model
  always @(negedge clk) begin
    tick = tick + 1;
    if (busy_cnt > 0) busy_cnt = busy_cnt - 1;
    if (!ce_n && !we_n) begin
      if (log_n < 64) begin
        log_d[log_n] = io_out; log_c[log_n] = cle;
        log_a[log_n] = ale;    log_t[log_n] = tick;
      end
      log_n = log_n + 1;
      if (!io_oe) oe_bad = oe_bad + 1;
      if (cle && io_out == 8'hD0) busy_cnt = blen;
    end
    if (!ce_n && !re_n) begin
      rd_n = rd_n + 1;
      if (io_oe) oe_bad = oe_bad + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (tick > WATCHDOG) begin
        errors++; checks++;
        $display("FAIL watchdog: actual %0d expected %0d", tick, WATCHDOG);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  task automatic pulse_start(input logic [23:0] a, input logic [23:0] b,
                             input logic p, input logic [15:0] t);
    @(negedge clk);
    row_a = a; row_b = b; poll = p; tmo = t; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_byte(input int i, input logic [23:0] a, input logic [23:0] b);
    case (i)
      0, 4: return 8'h60;
      1: return a[7:0];
      2: return a[15:8];
      3: return a[23:16];
      5: return b[7:0];
      6: return b[15:8];
      7: return b[23:16];
      default: return 8'hD0;
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check(ce_n && we_n && re_n && !cle && !ale && !io_oe, "R9 bus idle",
          {ce_n, we_n, re_n, cle, ale, io_oe}, 6'b111000);
    check(!busy && !done && !fail && !aerr && !terr, "R9 status low",
          {busy, done, fail, aerr, terr}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      vec_t c;
      bit seq_ok;
      bit gap_ok;
      c = VECS[v];
      log_n = 0; rd_n = 0; blen = 32'(c.blen); sfail = c.sfail;
      pulse_start(c.ra, c.rb, c.poll, c.tmo);
      wait_done();
      check(aerr == c.e_aerr, "R3 addr_err", aerr, c.e_aerr);
      check(fail == c.e_fail, "R6 fail", fail, c.e_fail);
      check(terr == c.e_tmo, "R7 timeout", terr, c.e_tmo);
      if (c.e_aerr) begin
        check(log_n == 0 && rd_n == 0, "R3 no bus cycle", log_n + rd_n, 0);
      end else begin
        seq_ok = log_n >= 9;
        gap_ok = seq_ok;
        for (int i = 0; i < 9 && i < log_n; i++) begin
          bit is_cmd;
          is_cmd = (i == 0 || i == 4 || i == 8);
          if (log_d[i] != exp_byte(i, c.ra, c.rb) || log_c[i] != is_cmd || log_a[i] == is_cmd)
            seq_ok = 1'b0;
          if (i > 0 && log_t[i] - log_t[i-1] != 3) gap_ok = 1'b0;
        end
        check(seq_ok, "R1 erase cycle order", log_n, 9);
        check(gap_ok, "R2 uniform 3-clock spacing", seq_ok ? log_t[4] - log_t[3] : -1, 3);
        if (!c.e_tmo) begin
          check(log_n == 10 && log_d[9] == 8'h70 && log_c[9], "R4/R5 status command",
                log_d[9], 8'h70);
          if (!c.poll) begin
            // R4: status only after guard and R/B# release
            check(log_t[9] - log_t[8] >= GUARD && log_t[9] - log_t[8] >= 32'(c.blen),
                  "R4 waits for ready", log_t[9] - log_t[8], c.blen);
            check(rd_n == 1, "R4 single status read", rd_n, 1);
          end else begin
            check(rd_n > 1, "R5 repeated polling", rd_n, 2);
          end
        end else begin
          while (busy_cnt > 0) @(negedge clk);
        end
      end
      // R8: done lasts one clock
      @(negedge clk);
      check(!done && !busy, "R8 done single pulse", {done, busy}, 0);
    end

    // R8: result flags hold while idle (last vector failed)
    repeat (5) @(negedge clk);
    check(fail == 1'b1, "R8 flag held", fail, 1);

    // R8: start while busy ignored
    log_n = 0; rd_n = 0; blen = 40; sfail = 1'b0;
    pulse_start(24'h000040, 24'h000000, 1'b0, 16'd1000);
    check(busy, "R8 busy after start", busy, 1);
    check(fail == 1'b0, "R8 flags cleared on start", fail, 0);
    repeat (4) @(negedge clk);
    pulse_start(24'h333333, 24'h444444, 1'b1, 16'd5);
    wait_done();
    check(log_n == 10 && log_d[1] == 8'h40, "R8 second start ignored", log_n, 10);
    check(!terr, "R8 second start timeout ignored", terr, 0);

    // R10: drive enable only on write cycles
    check(oe_bad == 0, "R10 output enable per cycle", oe_bad, 0);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule